// File: doc/BRIEF.md
# Shared-Word Interrupt Enable and Status Register

This block gathers a small group of level-type event lines into one parent interrupt. Each line has a sticky status flag, which a rising edge on the line sets, and an enable flag that software owns. Software sees both in one 32-bit word on a plain single-cycle register bus. The enable flags sit in the lower half of the word. The status flags sit in the upper half, and each one is exactly 16 bit positions above its own enable flag.

A status flag is cleared by writing 1 to it. Writing 0 to a status flag leaves it as it is, so software can change enables in the same word without losing pending events. The parent interrupt is a registered OR of every source whose status and enable flags are both set. A service routine reads the word, handles the pending sources from the lowest bit upward, and clears each one with its own write.

The source field may start at a bit offset (`BASE`) inside each half. The default layout has seven sources at offset 0. Another layout used here has two sources at offset 4.

Top module: `evt_irq_word`

## Requirements
- R1: The word is decoded only at bus address `REG_ADDR` (default 0). A read there returns the word with no clock delay. A read at any other address returns 0, and a write at any other address changes nothing.
- R2: Source k has its enable flag at bit `BASE+k` and its status flag at bit `16+BASE+k`. With the default layout, source 0 reads back as 0x00010000 when only its status is set.
- R3: A write at `REG_ADDR` loads every enable flag from the matching data bit. In the same cycle it clears each status flag whose data bit is 1, and keeps each status flag whose data bit is 0.
- R4: A 0-to-1 change on `src[k]` sets status flag k on that clock edge, whatever the enable flag holds. A line that stays high does not set the flag again after software clears it.
- R5: When a rising edge and a write-1 clear reach the same status flag in the same cycle, the flag ends up set.
- R6: `irq` goes high one clock after some source has both flags set. It goes low one clock after the last such pair is broken, whether by a clear or by disabling the source.
- R7: Word bits outside the configured enable and status fields always read 0 and ignore writes. Writing all ones to the default layout reads back 0x0000007F.
- R8: A synchronous low on `rst_n` clears all enable flags, all status flags and `irq`.
- R9: With `NUM_SRC=2` and `BASE=4`, the enables are bits 5:4 and the status flags are bits 21:20. Writing all ones to that layout reads back 0x00000030.
- R10: The default layout has seven sources: enables in bits 6:0 and status flags in bits 22:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src | input | NUM_SRC | Event lines; a rising edge sets the matching status flag |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe; the write takes effect on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq | output | 1 | Parent interrupt, registered |

## Verification
The bench targets these corner cases:
- A clear that meets a fresh edge in the same cycle. A design that gives the clear priority loses the event.
- A clear issued while the line is still high. A design that is level-triggered rather than edge-triggered sets the flag again at once.
- A write of 0 to a pending status flag that disables its source. A design that overwrites status instead of clearing it on 1 drops the pending event. A design that ignores the enable keeps `irq` high.
- Writing all ones to both the default layout and the offset layout, plus a write to a foreign address. These catch any field that is misplaced, any stray bit that can be written, and any decode that lets a foreign address through.

// File: rtl/evt_irq_pkg.sv
// Package: shared widths and layout helpers for the shared-word interrupt register.
// Assumes the word is 32 bits and that status sits one half-word above enable.
package evt_irq_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    // Bits of the word that belong to the enable field or to the status field.
    function automatic logic [WORD_W-1:0] field_mask(int n, int base);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[base + i]          = 1'b1;
            m[HALF_W + base + i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/evt_edge_detect.sv
// Module: evt_edge_detect
// Flags a 0-to-1 change on each event line, combinationally, in the cycle
// where the line is first seen high. Assumes the lines are already in the clk domain.
module evt_edge_detect #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    // Remember each line's level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // A rise is high now and low one cycle ago.
    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/evt_status_bank.sv
// Module: evt_status_bank
// Sticky per-source status flags: set by an event, cleared by a write-1 strobe.
// An event in the same cycle as a clear wins, so no event is lost.
module evt_status_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        // One sticky flag; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (set[i]) flag_q <= 1'b1;
            else if (clr[i]) flag_q <= 1'b0;
        end

        assign status[i] = flag_q;
    end
endmodule

// File: rtl/evt_enable_bank.sv
// Module: evt_enable_bank
// Per-source enable flags, loaded whole on every write that hits the word.
module evt_enable_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] enable
);
    logic [N-1:0] en_q;

    // Capture the enable field on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (load) en_q <= wdata;
    end

    assign enable = en_q;
endmodule

// File: rtl/evt_irq_merge.sv
// Module: evt_irq_merge
// Registered OR of status AND enable across all sources, giving one level-type
// parent interrupt. Adds one cycle of latency so the output is free of glitches.
module evt_irq_merge #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status,
    input  logic [N-1:0] enable,
    output logic         irq
);
    logic pending;
    logic irq_q;

    // Any source that is both pending and enabled.
    assign pending = |(status & enable);

    // Register the merged request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pending;
    end

    assign irq = irq_q;
endmodule

// File: rtl/evt_irq_word.sv
// Module: evt_irq_word (top)
// One 32-bit register holds both the enable flags (lower half) and the sticky
// status flags (upper half, write-1-to-clear) for NUM_SRC event lines that start
// at bit BASE. Drives a registered parent interrupt.
// Assumes: NUM_SRC + BASE <= 16, the event lines are synchronous to clk, and
// bus accesses take a single cycle.
module evt_irq_word
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC  = 7,
    parameter int BASE     = 0,
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq
);
    localparam int ST_LO = HALF_W + BASE;

    if (NUM_SRC < 1 || NUM_SRC + BASE > HALF_W) begin : g_bad_layout
        $error("evt_irq_word: source field does not fit in a half word");
    end

    logic               hit;
    logic               wr_hit;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [WORD_W-1:0]  word;

    // Address decode for the single register.
    assign hit    = (bus_addr == ADDR_W'(REG_ADDR));
    assign wr_hit = bus_wr & hit;

    // Write-1-to-clear strobes, taken from the status half of the data.
    assign clr = wr_hit ? bus_wdata[ST_LO +: NUM_SRC] : '0;

    evt_edge_detect #(.N(NUM_SRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (src),
        .rise  (rise)
    );

    evt_status_bank #(.N(NUM_SRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (rise),
        .clr    (clr),
        .status (status_q)
    );

    evt_enable_bank #(.N(NUM_SRC)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_hit),
        .wdata  (bus_wdata[BASE +: NUM_SRC]),
        .enable (enable_q)
    );

    evt_irq_merge #(.N(NUM_SRC)) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .enable (enable_q),
        .irq    (irq)
    );

    // Put both fields into the word; every other bit stays 0.
    always_comb begin
        word                     = '0;
        word[BASE +: NUM_SRC]    = enable_q;
        word[ST_LO +: NUM_SRC]   = status_q;
    end

    // Read mux: the word at its address, 0 anywhere else.
    assign bus_rdata = hit ? word : '0;
endmodule

// File: rtl/evt_irq_word_chk.sv
// Module: evt_irq_word_chk
// Checker bound to evt_irq_word. It relates the event lines, the bus and the
// internal flag registers over time.
module evt_irq_word_chk
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC  = 7,
    parameter int BASE     = 0,
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [WORD_W-1:0]  bus_wdata,
    input logic [WORD_W-1:0]  bus_rdata,
    input logic               irq,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] enable
);
    localparam logic [WORD_W-1:0] FIELDS = field_mask(NUM_SRC, BASE);

    logic hit_c;
    assign hit_c = (bus_addr == ADDR_W'(REG_ADDR));

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && enable == '0 && !irq));

    p_miss_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_c |-> bus_rdata == '0);

    p_miss_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_c) |=> $stable(enable));

    p_outside_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~FIELDS) == '0);

    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && (bus_rdata[HALF_W +: HALF_W] & bus_rdata[HALF_W-1:0]) != '0) |=> irq);

    p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && (bus_rdata[HALF_W +: HALF_W] & bus_rdata[HALF_W-1:0]) == '0) |=> !irq);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (src[i] && !$past(src[i])) |=> status[i]);

        p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && hit_c && bus_wdata[HALF_W+BASE+i] && !(src[i] && !$past(src[i])))
            |=> !status[i]);

        p_w0_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(bus_wr && hit_c && bus_wdata[HALF_W+BASE+i])) |=> status[i]);

        p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && hit_c && bus_wdata[HALF_W+BASE+i] && src[i] && !$past(src[i]))
            |=> status[i]);
    end
endmodule

bind evt_irq_word evt_irq_word_chk #(
    .NUM_SRC (NUM_SRC),
    .BASE    (BASE),
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .status   (status_q),
    .enable   (enable_q)
);

// File: tb/test_evt_irq_word.sv
// Bench for evt_irq_word: the default layout (7 sources at bit 0) and an
// offset layout (2 sources at bit 4) share one bus. A reference model built
// from the requirements is advanced on every clock edge.
module test_evt_irq_word;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_pos = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_a, rd_b;
    logic        irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    evt_irq_word #(.NUM_SRC(7), .BASE(0)) i_evt_irq_word (
        .clk(clk), .rst_n(rst_n), .src(src_pos[6:0]), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rd_a), .irq(irq_a)
    );

    evt_irq_word #(.NUM_SRC(2), .BASE(4)) i_evt_irq_word_alt (
        .clk(clk), .rst_n(rst_n), .src(src_pos[5:4]), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rd_b), .irq(irq_b)
    );

    localparam logic [15:0] MSK_A = 16'h007F;
    localparam logic [15:0] MSK_B = 16'h0030;

    // Reference state, with status kept in enable-bit positions.
    logic [15:0] a_en, a_st, a_prev, b_en, b_st, b_prev;
    logic        a_irq, b_irq;

    always @(posedge clk) begin
        logic [15:0] ea, eb;
        if (!rst_n) begin
            a_en = '0; a_st = '0; a_prev = '0; a_irq = 1'b0;
            b_en = '0; b_st = '0; b_prev = '0; b_irq = 1'b0;
        end else begin
            a_irq = |(a_st & a_en);
            b_irq = |(b_st & b_en);
            ea = src_pos & ~a_prev & MSK_A;
            eb = src_pos & ~b_prev & MSK_B;
            a_prev = src_pos & MSK_A;
            b_prev = src_pos & MSK_B;
            if (bus_wr && bus_addr == 4'd0) begin
                a_st = a_st & ~bus_wdata[31:16];
                b_st = b_st & ~bus_wdata[31:16];
                a_en = bus_wdata[15:0] & MSK_A;
                b_en = bus_wdata[15:0] & MSK_B;
            end
            a_st = (a_st | ea) & MSK_A;
            b_st = (b_st | eb) & MSK_B;
        end
    end

    function automatic logic [31:0] exp_read(logic [15:0] st, logic [15:0] en, logic [3:0] ad);
        return (ad == 4'd0) ? {st, en} : 32'h0;
    endfunction

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Compare both instances against the model.
    task automatic check_all(string tag);
        check_val({tag, " word A"}, rd_a, exp_read(a_st, a_en, bus_addr));
        check_val({tag, " irq A"}, {31'h0, irq_a}, {31'h0, a_irq});
        check_val({tag, " word B"}, rd_b, exp_read(b_st, b_en, bus_addr));
        check_val({tag, " irq B"}, {31'h0, irq_b}, {31'h0, b_irq});
    endtask

    // Drive one cycle of stimulus and move to the next falling edge.
    task automatic step(logic [3:0] ad, logic wr, logic [31:0] wd, logic [15:0] s);
        bus_addr = ad; bus_wr = wr; bus_wdata = wd; src_pos = s;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: state after reset
        check_all("R8");
        check_val("R8 reset word", rd_a, 32'h0);

        step(4'd0, 1'b0, 32'h0, 16'h0001);
        check_all("R4");
        check_val("R2 status 16 above enable", rd_a, 32'h0001_0000);

        step(4'd0, 1'b1, 32'h0000_0001, 16'h0001);
        check_all("R3 enable load");
        check_val("R6 irq not yet", {31'h0, irq_a}, 32'h0);
        step(4'd0, 1'b0, 32'h0, 16'h0001);
        check_val("R6 irq raised", {31'h0, irq_a}, 32'h1);

        step(4'd0, 1'b1, 32'h0001_0001, 16'h0001);
        check_val("R4 held line not re-set / R3 clear", rd_a, 32'h0000_0001);
        step(4'd0, 1'b0, 32'h0, 16'h0001);
        check_val("R6 irq drops after clear", {31'h0, irq_a}, 32'h0);

        step(4'd0, 1'b0, 32'h0, 16'h0000);
        step(4'd0, 1'b1, 32'h0001_0001, 16'h0001);
        check_val("R5 set wins over clear", rd_a, 32'h0001_0001);

        step(4'd0, 1'b1, 32'h0000_0000, 16'h0001);
        check_val("R3 write 0 keeps status", rd_a, 32'h0001_0000);
        check_all("R3");
        step(4'd0, 1'b0, 32'h0, 16'h0001);
        check_val("R6 irq drops on disable", {31'h0, irq_a}, 32'h0);

        step(4'd0, 1'b1, 32'hFFFF_FFFF, 16'h0000);
        check_val("R7 R10 all ones default", rd_a, 32'h0000_007F);
        check_val("R9 all ones offset", rd_b, 32'h0000_0030);

        step(4'd0, 1'b0, 32'h0, 16'h0010);
        check_val("R9 offset status bit 20", rd_b, 32'h0010_0030);
        check_val("R10 default source 4", rd_a, 32'h0010_007F);

        step(4'd3, 1'b1, 32'h0010_0000, 16'h0010);
        check_val("R1 foreign read A", rd_a, 32'h0);
        check_val("R1 foreign read B", rd_b, 32'h0);
        step(4'd0, 1'b0, 32'h0, 16'h0010);
        check_val("R1 foreign write ignored", rd_a, 32'h0010_007F);
        check_all("R1");

        // Random phase, checked each cycle against the model.
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  ad;
            logic        wr;
            logic [31:0] wd;
            logic [15:0] s;
            ad = ($urandom % 8 == 0) ? 4'($urandom) : 4'd0;
            wr = ($urandom % 3 == 0);
            wd = $urandom;
            s  = src_pos;
            if ($urandom % 3 == 0) s = s ^ 16'($urandom);
            step(ad, wr, wd, s);
            check_all("R3 R4 R5 R6 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule